// File: doc/BRIEF.md
# Dual-Modulus Programmable Prescaler

The prescaler divides a fast input clock by a base modulus N or by N+2, and delivers a square-wave output together with a single-cycle strobe at the start of every output period. Two static select inputs choose the base modulus (128, 256 or 512). A modulus-control input picks N or N+2 for each output period. It is meant to sit ahead of a slower counter chain in a frequency-synthesis loop. That chain counts output periods and drives the modulus-control input to swallow extra input cycles.

The two extra cycles of the N+2 ratio all go into the high half of the output period. The low half always lasts N/2 input cycles. The select and modulus-control inputs are sampled once per period, on the clock edge that starts the period. The ratio of a period therefore cannot change once that period has begun. A change on the modulus-control input takes effect from the next period start.

The control is a three-state machine. S_IDLE is held during reset. S_HIGH is the high half and S_LOW is the low half. There are three transitions. T_START goes from S_IDLE to S_HIGH on the first clock with reset low. T_FALL goes from S_HIGH to S_LOW when the high-half count ends. T_RISE goes from S_LOW to S_HIGH when the low-half count ends, and it also samples the ratio for the new period.

Top module: `dual_mod_prescaler`

## Requirements
- R1: With `sel_a`=1 and `sel_b`=1 the base modulus N is 128.
- R2: With exactly one of `sel_a`, `sel_b` at 1 the base modulus N is 256, and both such encodings behave identically.
- R3: With `sel_a`=0 and `sel_b`=0 the base modulus N is 512.
- R4: With `mod_ctl`=1 the output period is N input cycles: high for N/2 cycles, then low for N/2 cycles.
- R5: With `mod_ctl`=0 the output period is N+2 input cycles: high for N/2+2 cycles, then low for N/2 cycles.
- R6: `sel_a`, `sel_b` and `mod_ctl` are sampled only on the clock edge that starts a period (the rising edge of `div_out`). Changes made later in that period do not alter it, and they apply from the next period.
- R7: While `rst` is high, `div_out` is 1 and `period_strobe` is 0. On the first clock edge with `rst` low, a new period starts and `period_strobe` is 1.
- R8: `period_strobe` is 1 for exactly one input clock cycle per period: the first cycle of the high half, which coincides with each rising edge of `div_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_a | input | 1 | Base modulus select bit A |
| sel_b | input | 1 | Base modulus select bit B |
| mod_ctl | input | 1 | 1 selects N, 0 selects N+2 |
| div_out | output | 1 | Divided square-wave output |
| period_strobe | output | 1 | One-cycle pulse at the start of each period |

## Verification
The bench measures the high and low run lengths of whole periods for all four select encodings under both modulus-control levels, in orders that toggle the ratio from one period to the next. A design that spreads the two swallowed cycles over both halves gives a low half of N/2+1. A design that decodes only one of the single-high encodings gives the wrong length for the other. The bench also changes every control input ten cycles into a high half. A design that samples continuously would cut that period short, and a design that samples late would fail to apply the new ratio in the following period. Reset is applied in the middle of a low half. The output must return high at once, and the first period after release must start with a strobe and have full length.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HIGH = 2'd1,
        S_LOW  = 2'd2
    } psc_state_e;

    // Half of the base modulus for a select encoding.
    // Both high -> smallest modulus, one high -> double, none high -> quadruple.
    function automatic int unsigned base_half(input logic a, input logic b,
                                              input int unsigned log2_nmin);
        int unsigned unit;
        unit = 32'd1 << (log2_nmin - 1);
        if (a && b)
            return unit;
        else if (a ^ b)
            return unit * 2;
        else
            return unit * 4;
    endfunction

endpackage

// File: rtl/psc_ratio_latch.sv
module psc_ratio_latch #(
    parameter int unsigned LOG2_NMIN = 7,
    parameter int unsigned SWALLOW   = 2,
    parameter int unsigned LEN_W     = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             sel_a,
    input  logic             sel_b,
    input  logic             mod_ctl,
    output logic [LEN_W-1:0] hi_len,
    output logic [LEN_W-1:0] lo_len
);
    import prescaler_pkg::*;

    logic [LEN_W-1:0] half_d;
    logic [LEN_W-1:0] hi_d;

    always_comb begin
        half_d = LEN_W'(base_half(sel_a, sel_b, LOG2_NMIN));
        hi_d   = mod_ctl ? half_d : half_d + LEN_W'(SWALLOW);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len <= LEN_W'(base_half(1'b1, 1'b1, LOG2_NMIN));
            lo_len <= LEN_W'(base_half(1'b1, 1'b1, LOG2_NMIN));
        end else if (capture) begin
            hi_len <= hi_d;
            lo_len <= half_d;
        end
    end

endmodule

// File: rtl/psc_half_counter.sv
module psc_half_counter #(
    parameter int unsigned LEN_W = 9
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [LEN_W-1:0] len,
    output logic             at_start,
    output logic             at_end
);
    logic [LEN_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr)
            cnt <= '0;
        else if (at_end)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    always_comb begin
        at_start = (cnt == '0);
        at_end   = (cnt == len - 1'b1);
    end

endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler #(
    parameter int unsigned LOG2_NMIN = 7,
    parameter int unsigned SWALLOW   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_a,
    input  logic sel_b,
    input  logic mod_ctl,
    output logic div_out,
    output logic period_strobe
);
    import prescaler_pkg::*;

    localparam int unsigned MAX_HALF = (1 << (LOG2_NMIN + 1)) + SWALLOW;
    localparam int unsigned LEN_W    = $clog2(MAX_HALF + 1);

    psc_state_e       state, nxt;
    logic [LEN_W-1:0] hi_len, lo_len, cur_len;
    logic             at_start, at_end, capture, cnt_clr;

    // T_START from idle, or T_RISE at the end of the low half
    assign capture = (state == S_IDLE) || (state == S_LOW && at_end);
    assign cnt_clr = rst || (state == S_IDLE);
    assign cur_len = (state == S_LOW) ? lo_len : hi_len;

    psc_ratio_latch #(
        .LOG2_NMIN (LOG2_NMIN),
        .SWALLOW   (SWALLOW),
        .LEN_W     (LEN_W)
    ) u_ratio (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .sel_a   (sel_a),
        .sel_b   (sel_b),
        .mod_ctl (mod_ctl),
        .hi_len  (hi_len),
        .lo_len  (lo_len)
    );

    psc_half_counter #(
        .LEN_W (LEN_W)
    ) u_count (
        .clk      (clk),
        .clr      (cnt_clr),
        .len      (cur_len),
        .at_start (at_start),
        .at_end   (at_end)
    );

    always_ff @(posedge clk) begin
        if (rst)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: nxt = S_HIGH;
            S_HIGH: if (at_end) nxt = S_LOW;
            S_LOW:  if (at_end) nxt = S_HIGH;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        div_out       = (state != S_LOW);
        period_strobe = (state == S_HIGH) && at_start;
    end

endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
    parameter int unsigned LOG2_NMIN = 7,
    parameter int unsigned SWALLOW   = 2
) (
    input logic clk,
    input logic rst,
    input logic sel_a,
    input logic sel_b,
    input logic mod_ctl,
    input logic div_out,
    input logic period_strobe
);
    import prescaler_pkg::*;

    logic [2:0]  in_q, cap;
    logic        armed, prev_out;
    int unsigned hi_run, lo_run, exp_half;

    always_ff @(posedge clk) begin
        in_q     <= {sel_a, sel_b, mod_ctl};
        prev_out <= div_out;
        if (rst) begin
            armed  <= 1'b0;
            cap    <= 3'b111;
            hi_run <= 0;
            lo_run <= 0;
        end else begin
            if (period_strobe) begin
                armed  <= 1'b1;
                cap    <= in_q;
                hi_run <= 1;
            end else if (div_out) begin
                hi_run <= hi_run + 1;
            end
            if (!div_out)
                lo_run <= lo_run + 1;
            else
                lo_run <= 0;
        end
    end

    assign exp_half = base_half(cap[2], cap[1], LOG2_NMIN);

    assert_strobe_high_R8: assert property (@(posedge clk) disable iff (rst)
        period_strobe |-> div_out);
    assert_rise_strobes_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(div_out) |-> period_strobe);
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
        period_strobe |=> !period_strobe);
    assert_reset_outputs_R7: assert property (@(posedge clk)
        rst |=> (div_out && !period_strobe));
    assert_start_after_reset_R7: assert property (@(posedge clk)
        (!rst && $past(rst)) |=> period_strobe);
    assert_high_len_R5: assert property (@(posedge clk) disable iff (rst)
        (armed && prev_out && !div_out) |->
            (hi_run == exp_half + (cap[0] ? 0 : SWALLOW)));
    assert_low_len_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && period_strobe) |-> (lo_run == exp_half));

endmodule

bind dual_mod_prescaler psc_checker #(
    .LOG2_NMIN (LOG2_NMIN),
    .SWALLOW   (SWALLOW)
) u_psc_checker (
    .clk           (clk),
    .rst           (rst),
    .sel_a         (sel_a),
    .sel_b         (sel_b),
    .mod_ctl       (mod_ctl),
    .div_out       (div_out),
    .period_strobe (period_strobe)
);

// File: tb/test_dual_mod_prescaler.sv
`timescale 1ns/1ps
module test_dual_mod_prescaler;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_a = 1'b1, sel_b = 1'b1, mod_ctl = 1'b1;
    logic div_out, period_strobe;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    dual_mod_prescaler i_dual_mod_prescaler (
        .clk           (clk),
        .rst           (rst),
        .sel_a         (sel_a),
        .sel_b         (sel_b),
        .mod_ctl       (mod_ctl),
        .div_out       (div_out),
        .period_strobe (period_strobe)
    );

    // {sel_a, sel_b, mod_ctl} and expected high / low lengths
    localparam int NV = 10;
    localparam logic [2:0] VIN [NV] = '{3'b111, 3'b110, 3'b101, 3'b100, 3'b010,
                                        3'b011, 3'b001, 3'b000, 3'b110, 3'b111};
    localparam int VHI [NV] = '{64, 66, 128, 130, 130, 128, 256, 258, 66, 64};
    localparam int VLO [NV] = '{64, 64, 128, 128, 128, 128, 256, 256, 64, 64};
    localparam string VREQ [NV] = '{"R1 R4", "R1 R5", "R2 R4", "R2 R5", "R2 R5",
                                    "R2 R4", "R3 R4", "R3 R5", "R1 R5", "R1 R4"};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_strobe();
        do @(negedge clk); while (!period_strobe);
    endtask

    // Starts at a negedge showing the strobe; ends at the next such negedge.
    task automatic measure(input bit poke, output int hi, output int lo, output int nstb);
        hi = 0; lo = 0; nstb = 0;
        while (div_out) begin
            if (period_strobe) nstb++;
            hi++;
            if (poke && hi == 10) begin
                sel_a = 1'b0; sel_b = 1'b0; mod_ctl = 1'b0;
            end
            @(negedge clk);
        end
        while (!div_out) begin
            if (period_strobe) nstb++;
            lo++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(5ns * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int hi, lo, ns;
        repeat (4) @(negedge clk);
        // R7 reset state
        check(div_out === 1'b1, "R7 div_out in reset", int'(div_out), 1);
        check(period_strobe === 1'b0, "R7 strobe in reset", int'(period_strobe), 0);
        rst = 1'b0;
        @(negedge clk);
        check(period_strobe === 1'b1, "R7 strobe after release", int'(period_strobe), 1);
        measure(1'b0, hi, lo, ns);
        check(hi == 64, "R7 R1 first high", hi, 64);
        check(lo == 64, "R7 R1 first low", lo, 64);

        // vector table: each setting is driven, then the next full period measured
        for (int i = 0; i < NV; i++) begin
            {sel_a, sel_b, mod_ctl} = VIN[i];
            wait_strobe();
            measure(1'b0, hi, lo, ns);
            check(hi == VHI[i], {VREQ[i], " high"}, hi, VHI[i]);
            check(lo == VLO[i], {VREQ[i], " low"}, lo, VLO[i]);
            check(ns == 1, "R8 strobes per period", ns, 1);
            check(period_strobe === 1'b1 && div_out === 1'b1, "R8 strobe on rise",
                  int'(period_strobe), 1);
        end

        // R6: changes mid-period are ignored, then apply next period
        {sel_a, sel_b, mod_ctl} = 3'b111;
        wait_strobe();
        measure(1'b1, hi, lo, ns);
        check(hi == 64, "R6 mid-period change high", hi, 64);
        check(lo == 64, "R6 mid-period change low", lo, 64);
        measure(1'b0, hi, lo, ns);
        check(hi == 258, "R6 change applied next high", hi, 258);
        check(lo == 256, "R6 change applied next low", lo, 256);

        // R7: reset in the middle of a low half
        {sel_a, sel_b, mod_ctl} = 3'b100;
        wait_strobe();
        while (div_out) @(negedge clk);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(div_out === 1'b1, "R7 mid-run reset output", int'(div_out), 1);
        check(period_strobe === 1'b0, "R7 mid-run reset strobe", int'(period_strobe), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(period_strobe === 1'b1, "R7 restart strobe", int'(period_strobe), 1);
        measure(1'b0, hi, lo, ns);
        check(hi == 130, "R7 R2 restart high", hi, 130);
        check(lo == 128, "R7 R2 restart low", lo, 128);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule